// File: doc/BRIEF.md
# Deep Sleep Retention and Release Controller

This block keeps the small set of state that must outlive a deep low-power period and governs how the chip leaves that period. It holds two general-purpose semaphore words, a control word, a wake-source record and a release latch that keeps the I/O frozen after wake-up. These registers sit in an always-on domain that only a true power-on reset clears.

Software asks for deep sleep with a request strobe. A wake event or an external pin reset ends the period. After wake-up the I/O stay frozen until software clears the release latch. While the latch is set, software writes to the secondary oscillator enable are parked in a shadow bit. The parked value reaches the live enable one cycle after the latch clears.

A sticky deep-sleep status flag and a power-on flag together give a reset-cause code. Software reads it to tell a real power-up apart from a return out of deep sleep.

Top module: `dslp_retain_ctrl`

## Requirements
- R1: `por` high at a clock edge clears both semaphores, the control word, `wake_src`, `io_freeze`, `ds_status`, `osc_en` and `asleep`, and sets `por_flag`, so `reset_cause` reads 1.
- R2: `pin_rst` while asleep ends deep sleep and leaves the semaphores, control word, `wake_src`, `io_freeze` and `osc_en` unchanged. `io_rst_req` is high for exactly the cycle after each cycle in which `pin_rst` is high.
- R3: `io_freeze` is set when deep sleep is entered. It is cleared only by `sw_clr_release` taken while awake; ending sleep leaves it set.
- R4: `sw_osc_wr` while `io_freeze` is clear loads `sw_osc_val` into `osc_en` at the next edge. While `io_freeze` is set, the value is held and appears on `osc_en` one edge after `io_freeze` falls. A later direct write overrides it.
- R5: `ds_status` is set on entry to deep sleep. It is cleared only by `sw_clr_status` while awake; wake events and pin reset leave it set.
- R6: While asleep, a nonzero `wake_evt` ends sleep. If `wake_src` is zero, it records the lowest-index set event as a one-hot value (bit i for event i). Otherwise `wake_src` is unchanged. Events while awake are ignored. `sw_clr_wake` while awake zeroes `wake_src`.
- R7: `reset_cause` is 0 when both flags are clear, 1 when only `por_flag` is set, 2 when both `ds_status` and `por_flag` are set, and 3 when only `ds_status` is set.
- R8: `core_boot` sets `por_flag` and changes none of the retained registers. `sw_clr_por` clears `por_flag` when `core_boot` is low.
- R9: `sw_wr_en` writes `sw_wdata` into semaphore 0 for `sw_sel`=0, semaphore 1 for 1 and the control word for 2; `sw_sel`=3 changes nothing.
- R10: `sleep_req` while asleep has no effect. `sleep_req` in the same cycle as `pin_rst` does not enter deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por | input | 1 | True power-on reset, synchronous, active high |
| core_boot | input | 1 | Core power-up after a powered-down deep sleep |
| pin_rst | input | 1 | External pin reset |
| sleep_req | input | 1 | Request to enter deep sleep |
| wake_evt | input | WAKE_W | Wake event lines |
| sw_wr_en | input | 1 | Software write strobe for retained words |
| sw_sel | input | 2 | Retained word select |
| sw_wdata | input | DATA_W | Write data |
| sw_clr_release | input | 1 | Software clear of the release latch |
| sw_clr_wake | input | 1 | Software clear of the wake record |
| sw_clr_status | input | 1 | Software clear of the deep-sleep status flag |
| sw_clr_por | input | 1 | Software clear of the power-on flag |
| sw_osc_wr | input | 1 | Software write of the secondary oscillator enable |
| sw_osc_val | input | 1 | Value for that write |
| asleep | output | 1 | Deep sleep in progress |
| io_freeze | output | 1 | I/O held in frozen state (release latch) |
| io_rst_req | output | 1 | Request to return I/O to pin-reset state |
| osc_en | output | 1 | Live secondary oscillator enable |
| sem0_q | output | DATA_W | Semaphore word 0 |
| sem1_q | output | DATA_W | Semaphore word 1 |
| ctrl_q | output | DATA_W | Control word |
| wake_src | output | WAKE_W | One-hot first wake cause |
| ds_status | output | 1 | Deep-sleep status flag |
| por_flag | output | 1 | Power-on flag |
| reset_cause | output | 2 | Decoded reset cause |

## Verification
The hardest state to reach holds a parked oscillator write and a pin reset inside one deep-sleep period. It then needs a release clear and, on the following cycle, a competing direct write. The stimulus enters sleep, writes the oscillator bit while frozen and wakes by pin reset. It checks that the retained words and the parked value survive. It then clears the release latch and probes both the plain transfer and the override. A behavioural model, fed the same strobes, compares every output after every edge.

// File: rtl/dslp_pkg.sv
package dslp_pkg;
  typedef enum logic [1:0] {
    CAUSE_OTHER       = 2'd0,
    CAUSE_POWER_ON    = 2'd1,
    CAUSE_DS_POWERED  = 2'd2,
    CAUSE_DS_RETAINED = 2'd3
  } cause_e;

  localparam int unsigned NUM_RET = 3;
  localparam int unsigned SEL_W   = 2;
endpackage

// File: rtl/dslp_retain_bank.sv
module dslp_retain_bank
  import dslp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sem0_q,
  output logic [DATA_W-1:0] sem1_q,
  output logic [DATA_W-1:0] ctrl_q
);
  logic [DATA_W-1:0] word_q [NUM_RET];

  for (genvar i = 0; i < NUM_RET; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (por)
        word_q[i] <= '0;
      else if (wr_en && sel == SEL_W'(i))
        word_q[i] <= wdata;
    end

    // R9: an unselected word keeps its value
    a_r9_word_hold: assert property (@(posedge clk) disable iff (por)
      !(wr_en && sel == SEL_W'(i)) |=> $stable(word_q[i]));
  end

  assign sem0_q = word_q[0];
  assign sem1_q = word_q[1];
  assign ctrl_q = word_q[2];
endmodule

// File: rtl/dslp_power_ctl.sv
module dslp_power_ctl #(
  parameter int unsigned WAKE_W = 4
) (
  input  logic              clk,
  input  logic              por,
  input  logic              pin_rst,
  input  logic              sleep_req,
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic              clr_release,
  input  logic              clr_wake,
  input  logic              clr_status,
  output logic              asleep,
  output logic              release_q,
  output logic              status_q,
  output logic              io_rst_req,
  output logic [WAKE_W-1:0] wake_src
);
  logic              any_wake;
  logic [WAKE_W-1:0] first_evt;

  assign any_wake  = |wake_evt;
  assign first_evt = wake_evt & (~wake_evt + WAKE_W'(1));

  always_ff @(posedge clk) begin
    if (por) begin
      asleep     <= 1'b0;
      release_q  <= 1'b0;
      status_q   <= 1'b0;
      io_rst_req <= 1'b0;
      wake_src   <= '0;
    end else begin
      io_rst_req <= pin_rst;
      if (!asleep) begin
        if (sleep_req && !pin_rst) begin
          asleep    <= 1'b1;
          release_q <= 1'b1;
          status_q  <= 1'b1;
        end else begin
          if (clr_release) release_q <= 1'b0;
          if (clr_status)  status_q  <= 1'b0;
        end
        if (clr_wake) wake_src <= '0;
      end else begin
        if (pin_rst || any_wake) asleep <= 1'b0;
        if (any_wake && wake_src == '0) wake_src <= first_evt;
      end
    end
  end

  // R3: freeze only drops through a software clear while awake
  a_r3_freeze_sticky: assert property (@(posedge clk) disable iff (por)
    release_q && !(clr_release && !asleep) |=> release_q);
  // R3: entering sleep always freezes the I/O
  a_r3_freeze_on_entry: assert property (@(posedge clk) disable iff (por)
    $rose(asleep) |-> release_q);
  // R5: status flag is sticky
  a_r5_status_sticky: assert property (@(posedge clk) disable iff (por)
    status_q && !clr_status |=> status_q);
  // R6: wake record is one-hot or empty
  a_r6_wake_onehot: assert property (@(posedge clk) disable iff (por)
    $onehot0(wake_src));
  // R2: I/O reset request follows a pin reset by one cycle
  a_r2_iorst_follows_pin: assert property (@(posedge clk) disable iff (por)
    io_rst_req |-> $past(pin_rst));
endmodule

// File: rtl/dslp_osc_hold.sv
module dslp_osc_hold (
  input  logic clk,
  input  logic por,
  input  logic release_q,
  input  logic osc_wr,
  input  logic osc_val,
  output logic osc_en
);
  logic shadow_q;
  logic pend_q;
  logic rel_d_q;
  logic rel_fell;

  assign rel_fell = rel_d_q && !release_q;

  always_ff @(posedge clk) begin
    if (por) begin
      osc_en   <= 1'b0;
      shadow_q <= 1'b0;
      pend_q   <= 1'b0;
      rel_d_q  <= 1'b0;
    end else begin
      rel_d_q <= release_q;
      if (osc_wr && release_q) begin
        shadow_q <= osc_val;
        pend_q   <= 1'b1;
      end else if (osc_wr) begin
        osc_en <= osc_val;
        pend_q <= 1'b0;
      end else if (pend_q && rel_fell) begin
        osc_en <= shadow_q;
        pend_q <= 1'b0;
      end
    end
  end

  // R4: live enable cannot move while the release latch is set
  a_r4_held_while_frozen: assert property (@(posedge clk) disable iff (por)
    release_q |=> $stable(osc_en));
endmodule

// File: rtl/dslp_cause.sv
module dslp_cause
  import dslp_pkg::*;
(
  input  logic   clk,
  input  logic   por,
  input  logic   core_boot,
  input  logic   clr_por,
  input  logic   status_q,
  output logic   por_flag,
  output cause_e cause
);
  always_ff @(posedge clk) begin
    if (por)            por_flag <= 1'b1;
    else if (core_boot) por_flag <= 1'b1;
    else if (clr_por)   por_flag <= 1'b0;
  end

  always_comb begin
    unique case ({status_q, por_flag})
      2'b00:   cause = CAUSE_OTHER;
      2'b01:   cause = CAUSE_POWER_ON;
      2'b11:   cause = CAUSE_DS_POWERED;
      default: cause = CAUSE_DS_RETAINED;
    endcase
  end

  // R8: power-on flag stays until software clears it
  a_r8_por_flag_sticky: assert property (@(posedge clk) disable iff (por)
    por_flag && !clr_por |=> por_flag);
endmodule

// File: rtl/dslp_retain_ctrl.sv
module dslp_retain_ctrl
  import dslp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WAKE_W = 4
) (
  input  logic              clk,
  input  logic              por,
  input  logic              core_boot,
  input  logic              pin_rst,
  input  logic              sleep_req,
  input  logic [WAKE_W-1:0] wake_evt,
  input  logic              sw_wr_en,
  input  logic [1:0]        sw_sel,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              sw_clr_release,
  input  logic              sw_clr_wake,
  input  logic              sw_clr_status,
  input  logic              sw_clr_por,
  input  logic              sw_osc_wr,
  input  logic              sw_osc_val,
  output logic              asleep,
  output logic              io_freeze,
  output logic              io_rst_req,
  output logic              osc_en,
  output logic [DATA_W-1:0] sem0_q,
  output logic [DATA_W-1:0] sem1_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [WAKE_W-1:0] wake_src,
  output logic              ds_status,
  output logic              por_flag,
  output logic [1:0]        reset_cause
);
  cause_e cause;

  dslp_retain_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .por(por), .wr_en(sw_wr_en), .sel(sw_sel), .wdata(sw_wdata),
    .sem0_q(sem0_q), .sem1_q(sem1_q), .ctrl_q(ctrl_q));

  dslp_power_ctl #(.WAKE_W(WAKE_W)) u_pwr (
    .clk(clk), .por(por), .pin_rst(pin_rst), .sleep_req(sleep_req),
    .wake_evt(wake_evt), .clr_release(sw_clr_release), .clr_wake(sw_clr_wake),
    .clr_status(sw_clr_status), .asleep(asleep), .release_q(io_freeze),
    .status_q(ds_status), .io_rst_req(io_rst_req), .wake_src(wake_src));

  dslp_osc_hold u_osc (
    .clk(clk), .por(por), .release_q(io_freeze), .osc_wr(sw_osc_wr),
    .osc_val(sw_osc_val), .osc_en(osc_en));

  dslp_cause u_cause (
    .clk(clk), .por(por), .core_boot(core_boot), .clr_por(sw_clr_por),
    .status_q(ds_status), .por_flag(por_flag), .cause(cause));

  assign reset_cause = cause;

  // R2: a pin reset during sleep leaves the retained words untouched
  a_r2_pin_keeps_words: assert property (@(posedge clk) disable iff (por)
    asleep && pin_rst && !sw_wr_en |=> $stable(sem0_q) && $stable(sem1_q) && $stable(ctrl_q));
  // R10: a pin reset blocks sleep entry in the same cycle
  a_r10_pin_blocks_entry: assert property (@(posedge clk) disable iff (por)
    !asleep && pin_rst |=> !asleep);
endmodule

// File: tb/dslp_retain_ctrl_test.sv
module dslp_retain_ctrl_test;
  localparam int DW = 16;
  localparam int WW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por = 1'b1, core_boot = 0, pin_rst = 0, sleep_req = 0;
  logic [WW-1:0] wake_evt = '0;
  logic sw_wr_en = 0;
  logic [1:0] sw_sel = '0;
  logic [DW-1:0] sw_wdata = '0;
  logic sw_clr_release = 0, sw_clr_wake = 0, sw_clr_status = 0, sw_clr_por = 0;
  logic sw_osc_wr = 0, sw_osc_val = 0;
  logic asleep, io_freeze, io_rst_req, osc_en, ds_status, por_flag;
  logic [DW-1:0] sem0_q, sem1_q, ctrl_q;
  logic [WW-1:0] wake_src;
  logic [1:0] reset_cause;

  dslp_retain_ctrl #(.DATA_W(DW), .WAKE_W(WW)) uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_word[3];
  int m_asleep, m_rel, m_stat, m_iorst, m_wake, m_osc, m_sh, m_pend, m_prevrel, m_porf;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_cause();
    if (m_stat == 0) return (m_porf != 0) ? 1 : 0;
    return (m_porf != 0) ? 2 : 3;
  endfunction

  task automatic model_edge();
    int old_rel;
    if (por) begin
      foreach (m_word[i]) m_word[i] = 0;
      m_asleep = 0; m_rel = 0; m_stat = 0; m_iorst = 0; m_wake = 0;
      m_osc = 0; m_sh = 0; m_pend = 0; m_prevrel = 0; m_porf = 1;
      return;
    end
    old_rel = m_rel;
    m_iorst = pin_rst;
    if (sw_osc_wr && old_rel != 0) begin m_sh = sw_osc_val; m_pend = 1; end
    else if (sw_osc_wr) begin m_osc = sw_osc_val; m_pend = 0; end
    else if (m_pend != 0 && old_rel == 0 && m_prevrel != 0) begin m_osc = m_sh; m_pend = 0; end
    m_prevrel = old_rel;
    if (core_boot) m_porf = 1; else if (sw_clr_por) m_porf = 0;
    if (sw_wr_en && sw_sel != 2'd3) m_word[sw_sel] = sw_wdata;
    if (m_asleep == 0) begin
      if (sleep_req && !pin_rst) begin m_asleep = 1; m_rel = 1; m_stat = 1; end
      else begin
        if (sw_clr_release) m_rel = 0;
        if (sw_clr_status) m_stat = 0;
      end
      if (sw_clr_wake) m_wake = 0;
    end else begin
      if (pin_rst || wake_evt != 0) m_asleep = 0;
      if (wake_evt != 0 && m_wake == 0)
        for (int i = WW - 1; i >= 0; i--) if (wake_evt[i]) m_wake = 1 << i;
    end
  endtask

  task automatic compare_all();
    chk("R9 sem0", sem0_q, m_word[0]);
    chk("R9 sem1", sem1_q, m_word[1]);
    chk("R9 ctrl", ctrl_q, m_word[2]);
    chk("R10 asleep", asleep, m_asleep);
    chk("R3 io_freeze", io_freeze, m_rel);
    chk("R2 io_rst_req", io_rst_req, m_iorst);
    chk("R4 osc_en", osc_en, m_osc);
    chk("R6 wake_src", wake_src, m_wake);
    chk("R5 ds_status", ds_status, m_stat);
    chk("R8 por_flag", por_flag, m_porf);
    chk("R7 reset_cause", reset_cause, exp_cause());
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    core_boot = 0; pin_rst = 0; sleep_req = 0; wake_evt = '0; sw_wr_en = 0;
    sw_clr_release = 0; sw_clr_wake = 0; sw_clr_status = 0; sw_clr_por = 0; sw_osc_wr = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [DW-1:0] d);
    sw_wr_en = 1; sw_sel = s; sw_wdata = d; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); por = 1; tick(); por = 0;
    // R1: reset state
    chk("R1 cause after por", reset_cause, 1);
    chk("R1 freeze after por", io_freeze, 0);
    // R9: writes, sel 3 ignored
    wr(2'd0, 16'hA5A5); wr(2'd1, 16'h1234); wr(2'd2, 16'h00FF); wr(2'd3, 16'hDEAD);
    chk("R9 ctrl kept after sel3", ctrl_q, 16'h00FF);
    // R4: direct write while unfrozen
    sw_osc_wr = 1; sw_osc_val = 1; tick();
    chk("R4 direct osc write", osc_en, 1);
    // R3 R5: entry
    sleep_req = 1; tick();
    chk("R3 freeze on entry", io_freeze, 1);
    chk("R7 cause both set", reset_cause, 2);
    sleep_req = 1; tick();  // R10: ignored while asleep
    wake_evt = 4'b0110; tick();
    chk("R6 first wake one-hot", wake_src, 4'b0010);
    chk("R3 freeze after wake", io_freeze, 1);
    // R4: held write, then release
    sw_osc_wr = 1; sw_osc_val = 0; tick();
    chk("R4 held while frozen", osc_en, 1);
    sw_clr_release = 1; tick();
    chk("R4 not yet on clear edge", osc_en, 1);
    tick();
    chk("R4 applied after clear", osc_en, 0);
    // R7 R8
    sw_clr_status = 1; sw_clr_por = 1; tick();
    chk("R7 cause other", reset_cause, 0);
    core_boot = 1; tick();
    chk("R8 boot keeps sem0", sem0_q, 16'hA5A5);
    chk("R8 cause power-on", reset_cause, 1);
    // R6: second sleep, wake record not overwritten
    sleep_req = 1; tick();
    wake_evt = 4'b0001; tick();
    chk("R6 record kept", wake_src, 4'b0010);
    wake_evt = 4'b1000; tick();  // awake: ignored
    sw_clr_wake = 1; tick();
    chk("R6 cleared", wake_src, 0);
    sw_clr_release = 1; sw_clr_por = 1; tick();
    // R2: pin reset during sleep with parked osc write
    sleep_req = 1; tick();
    sw_osc_wr = 1; sw_osc_val = 1; tick();
    pin_rst = 1; tick();
    chk("R2 awake after pin", asleep, 0);
    chk("R2 io reset pulse", io_rst_req, 1);
    chk("R2 freeze kept", io_freeze, 1);
    chk("R7 cause retained exit", reset_cause, 3);
    tick();
    chk("R2 pulse one cycle", io_rst_req, 0);
    // R4 override: clear, then direct write on the transfer edge
    sw_clr_release = 1; tick();
    sw_osc_wr = 1; sw_osc_val = 0; tick();
    chk("R4 direct overrides parked", osc_en, 0);
    // R10: pin reset blocks entry
    sleep_req = 1; pin_rst = 1; tick();
    chk("R10 no entry with pin", asleep, 0);
    // R1: por mid-run
    por = 1; tick(); por = 0;
    chk("R1 sem0 cleared", sem0_q, 0);
    tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule